// File: doc/BRIEF.md
# Paired Element Transpose Unit

This unit performs many independent 2x2 element transposes across two 128-bit source vectors in one operation. Element pairs are formed per lane index: the "even" result collects the even-indexed element of each pair from both sources, and the "odd" result collects the odd-indexed element of each pair from both sources. Each result interleaves the two sources. Software builds a full NxN matrix transpose by applying the unit repeatedly, doubling the element width at each pass. A 4x4 block of 16-bit values takes one 16-bit pass and then one 32-bit pass.

A mode input picks the even result, the odd result, or both at once. In the both mode the two results appear on two separate output buses in the same cycle, so one issued operation fills a destination pair. An element-width input regroups each vector into 16, 8 or 4 lanes. The operation is wrapped in a valid/ready handshake with a single registered output stage, so a result is presented one cycle after it is accepted.

Top module: `trn_pair_unit`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1, and both `resA` and `resB` are all zeros.
- R2: Mode 0 (even) places on `resA`, for every pair index i: lane 2i = `srcA` lane 2i and lane 2i+1 = `srcB` lane 2i.
- R3: Mode 1 (odd) places on `resA`, for every pair index i: lane 2i = `srcA` lane 2i+1 and lane 2i+1 = `srcB` lane 2i+1.
- R4: Mode 2 (both) places the even result on `resA` and the odd result on `resB` in the same cycle. Mode 3 behaves exactly like mode 2.
- R5: `elemWidth` code 0 selects 8-bit lanes (16 lanes), code 1 selects 16-bit lanes (8 lanes), and code 2 selects 32-bit lanes (4 lanes). Code 3 behaves like code 2. Lane k occupies bits [k*W +: W].
- R6: An operation is accepted on a rising edge where `inValid` and `inReady` are both 1. `outValid` is 1 and the result is on the buses after that same edge, so the result is visible one cycle after acceptance. Acceptances on consecutive cycles are allowed when `outReady` is 1.
- R7: While `outValid` is 1 and `outReady` is 0, `inReady` is 0, `outValid` stays 1, and `resA` and `resB` hold their values. A presented input is not accepted during that time.
- R8: In modes 0 and 1 `resB` keeps the value it had before the operation.
- R9: For 16-bit rows abcd/efgh/ijkl/mnop, a 16-bit pass in both mode on row pairs (0,1) and (2,3) followed by a 32-bit pass in both mode yields rows aeim/bfjn/cgko/dhlp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operands and controls are presented |
| inReady | output | 1 | Unit can take an operation this cycle |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| mode | input | 2 | 0 even, 1 odd, 2/3 both |
| elemWidth | input | 2 | 0 byte, 1 halfword, 2/3 word lanes |
| outValid | output | 1 | Result buses hold a valid result |
| outReady | input | 1 | Consumer takes the result this cycle |
| resA | output | 128 | Primary destination (even, or odd in mode 1) |
| resB | output | 128 | Second destination (odd result in both mode) |

## Verification
On every cycle the assertions check the handshake rules: an accept raises `outValid`, a stalled result stays valid with both buses frozen and input blocked, and `resB` is untouched by single-result operations. The lane mapping itself can only be shown by the bench scenarios. These cover each width and mode against an independently computed reference, the reserved codes, and back-to-back and stalled traffic. The bench also runs a two-pass 4x4 transpose compared against a plain matrix transpose.

// File: rtl/trn_pair_pkg.sv
package trn_pair_pkg;
  localparam int VecBits   = 128;
  localparam int NumWidths = 3;

  typedef enum logic [1:0] {
    MODE_EVEN  = 2'd0,
    MODE_ODD   = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_BOTH2 = 2'd3
  } trnMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capA;       // load primary result register
    logic capB;       // load second result register
    logic aTakesOdd;  // primary register gets odd result
  } trnStrobe_t;
endpackage

// File: rtl/trn_pair_ctrl.sv
module trn_pair_ctrl
  import trn_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output trnStrobe_t strobe
);
  logic accept;
  trnMode_e modeE;

  assign modeE   = trnMode_e'(mode);
  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.capA      = accept;
    strobe.capB      = accept && (modeE == MODE_BOTH || modeE == MODE_BOTH2);
    strobe.aTakesOdd = (modeE == MODE_ODD);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outValid <= 1'b0;
    else if (accept)    outValid <= 1'b1;
    else if (outReady)  outValid <= 1'b0;
  end

  // R6
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R7
  stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R7
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: rtl/trn_pair_dp.sv
module trn_pair_dp
  import trn_pair_pkg::*;
#(
  parameter int VLEN = VecBits
) (
  input  logic            clk,
  input  logic            rstN,
  input  trnStrobe_t      strobe,
  input  logic [1:0]      elemWidth,
  input  logic [VLEN-1:0] srcA,
  input  logic [VLEN-1:0] srcB,
  output logic [VLEN-1:0] resA,
  output logic [VLEN-1:0] resB
);
  logic [VLEN-1:0] evenRes [NumWidths];
  logic [VLEN-1:0] oddRes  [NumWidths];
  logic [1:0]      widthIdx;
  logic [VLEN-1:0] evenSel, oddSel;

  for (genvar g = 0; g < NumWidths; g++) begin : gWidth
    localparam int EW    = 8 << g;
    localparam int LANES = VLEN / EW;
    logic [VLEN-1:0] ev, od;
    for (genvar p = 0; p < LANES / 2; p++) begin : gPair
      assign ev[(2*p)*EW   +: EW] = srcA[(2*p)*EW   +: EW];
      assign ev[(2*p+1)*EW +: EW] = srcB[(2*p)*EW   +: EW];
      assign od[(2*p)*EW   +: EW] = srcA[(2*p+1)*EW +: EW];
      assign od[(2*p+1)*EW +: EW] = srcB[(2*p+1)*EW +: EW];
    end
    assign evenRes[g] = ev;
    assign oddRes[g]  = od;
  end

  always_comb begin
    case (elemWidth)
      2'd0:    widthIdx = 2'd0;
      2'd1:    widthIdx = 2'd1;
      default: widthIdx = 2'd2;
    endcase
    evenSel = evenRes[widthIdx];
    oddSel  = oddRes[widthIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resA <= '0;
      resB <= '0;
    end else begin
      if (strobe.capA) resA <= strobe.aTakesOdd ? oddSel : evenSel;
      if (strobe.capB) resB <= oddSel;
    end
  end

  // R8
  single_keeps_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && !strobe.capB) |=> $stable(resB));

  // R7
  idle_keeps_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capA |=> $stable(resA));
endmodule

// File: rtl/trn_pair_unit.sv
module trn_pair_unit
  import trn_pair_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  input  logic [1:0]   mode,
  input  logic [1:0]   elemWidth,
  output logic         outValid,
  input  logic         outReady,
  output logic [127:0] resA,
  output logic [127:0] resB
);
  trnStrobe_t strobe;

  trn_pair_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .strobe(strobe)
  );

  trn_pair_dp #(.VLEN(VecBits)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elemWidth(elemWidth),
    .srcA(srcA), .srcB(srcB), .resA(resA), .resB(resB)
  );

  // R7
  stall_holds_bufs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(resA) && $stable(resB)));
endmodule

// File: tb/trn_pair_unit_test.sv
module trn_pair_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b1;
  logic [127:0] srcA = '0, srcB = '0;
  logic [1:0] mode = 2'd0, elemWidth = 2'd0;
  logic inReady, outValid;
  logic [127:0] resA, resB;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trn_pair_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .srcA(srcA), .srcB(srcB), .mode(mode), .elemWidth(elemWidth),
    .outValid(outValid), .outReady(outReady), .resA(resA), .resB(resB)
  );

  function automatic logic [127:0] refTrn(input logic [127:0] a, input logic [127:0] b,
                                          input logic [1:0] ew, input bit odd);
    logic [127:0] r = '0;
    int w = (ew == 2'd0) ? 8 : (ew == 2'd1) ? 16 : 32;
    for (int k = 0; k < 128 / w; k++) begin
      int src = odd ? ((k / 2) * 2 + 1) : ((k / 2) * 2);
      for (int bt = 0; bt < w; bt++)
        r[k*w + bt] = (k % 2 == 0) ? a[src*w + bt] : b[src*w + bt];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one op with outReady high; sample at the following negedge
  task automatic runOp(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] m, input logic [1:0] ew);
    @(negedge clk);
    srcA = a; srcB = b; mode = m; elemWidth = ew; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 outValid", {127'd0, outValid}, 128'd0);
    check("R1 inReady", {127'd0, inReady}, 128'd1);
    check("R1 resA", resA, '0);
    check("R1 resB", resB, '0);
  endtask

  task automatic testSingle(input logic [127:0] a, input logic [127:0] b, input logic [1:0] ew);
    logic [127:0] prevB;
    prevB = resB;
    runOp(a, b, 2'd0, ew);
    check("R2 R5 even", resA, refTrn(a, b, ew, 1'b0));
    check("R8 resB after even", resB, prevB);
    runOp(a, b, 2'd1, ew);
    check("R3 R5 odd", resA, refTrn(a, b, ew, 1'b1));
    check("R8 resB after odd", resB, prevB);
    check("R6 outValid", {127'd0, outValid}, 128'd1);
  endtask

  task automatic testBoth(input logic [127:0] a, input logic [127:0] b,
                          input logic [1:0] m, input logic [1:0] ew);
    runOp(a, b, m, ew);
    check("R4 both resA", resA, refTrn(a, b, ew, 1'b0));
    check("R4 both resB", resB, refTrn(a, b, ew, 1'b1));
  endtask

  task automatic testBackToBack();
    logic [127:0] a1 = 128'h0f0e0d0c0b0a09080706050403020100;
    logic [127:0] a2 = 128'hfedcba98765432100123456789abcdef;
    logic [127:0] b1 = ~a1;
    @(negedge clk);
    srcA = a1; srcB = b1; mode = 2'd0; elemWidth = 2'd1; inValid = 1'b1;
    @(negedge clk);
    check("R6 first result", resA, refTrn(a1, b1, 2'd1, 1'b0));
    srcA = a2;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 second result", resA, refTrn(a2, b1, 2'd1, 1'b0));
    @(negedge clk);
    check("R6 valid drops", {127'd0, outValid}, 128'd0);
  endtask

  task automatic testStall();
    logic [127:0] x = 128'h1111222233334444555566667777aaaa;
    logic [127:0] y = 128'h99998888777766665555444433332222;
    logic [127:0] expX = refTrn(x, y, 2'd2, 1'b0);
    logic [127:0] expXB = refTrn(x, y, 2'd2, 1'b1);
    @(negedge clk);
    outReady = 1'b0;
    srcA = x; srcB = y; mode = 2'd2; elemWidth = 2'd2; inValid = 1'b1;
    @(negedge clk);
    srcA = y; srcB = x;
    @(negedge clk);
    @(negedge clk);
    check("R7 resA held", resA, expX);
    check("R7 resB held", resB, expXB);
    check("R7 inReady low", {127'd0, inReady}, 128'd0);
    check("R7 outValid held", {127'd0, outValid}, 128'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 pending op taken after release", resA, refTrn(y, x, 2'd2, 1'b0));
  endtask

  task automatic testMatrix();
    logic [15:0] m [4][4];
    logic [127:0] row [4];
    logic [127:0] s1 [4];
    logic [127:0] fin [4];
    for (int r = 0; r < 4; r++) begin
      row[r] = '0;
      for (int c = 0; c < 4; c++) begin
        m[r][c] = 16'h0a00 + 16'(r * 4 + c);
        row[r][c*16 +: 16] = m[r][c];
      end
    end
    runOp(row[0], row[1], 2'd2, 2'd1); s1[0] = resA; s1[1] = resB;
    runOp(row[2], row[3], 2'd2, 2'd1); s1[2] = resA; s1[3] = resB;
    runOp(s1[0], s1[2], 2'd2, 2'd2); fin[0] = resA; fin[2] = resB;
    runOp(s1[1], s1[3], 2'd2, 2'd2); fin[1] = resA; fin[3] = resB;
    for (int r = 0; r < 4; r++) begin
      logic [63:0] expRow;
      for (int c = 0; c < 4; c++) expRow[c*16 +: 16] = m[c][r];
      check("R9 transposed row", {64'd0, fin[r][63:0]}, {64'd0, expRow});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle(128'h0f0e0d0c0b0a09080706050403020100, 128'h1f1e1d1c1b1a19181716151413121110, 2'd0);
    testBoth(128'hdeadbeef00112233445566778899aabb, 128'hcafef00d0123456789abcdef76543210, 2'd2, 2'd1);
    testSingle(128'h00070006000500040003000200010000, 128'h10071006100510041003100210011000, 2'd1);
    testSingle(128'h33333333222222221111111100000000, 128'hbbbbbbbbaaaaaaaa9999999988888888, 2'd2);
    testSingle(128'h0123456789abcdeffedcba9876543210, 128'h55aa55aa00ff00ff123456789abcdef0, 2'd3);
    testBoth(128'h0f0e0d0c0b0a09080706050403020100, 128'hf0e0d0c0b0a090807060504030201000, 2'd3, 2'd0);
    testBackToBack();
    testStall();
    testMatrix();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule